// File: doc/BRIEF.md
# Serial-bus slave command decoder

This block is the write-side front end of a serial management bus slave in a configurable supply supervisor. Both bus lines are sampled through two-flop synchronisers on the system clock. The block detects start and stop conditions and shifts in bytes on rising SCL. After each byte it decides whether to acknowledge by pulling SDA low through an open-drain enable for the ninth clock. The first byte after a start is compared against a fixed four-bit device type and two strap pins, so up to four instances can share one bus.

A write transaction carries a command byte and then up to two data bytes. Command codes 00h to 45h address a 70-entry register bank, and the decoder presents those stores on a single-cycle write port. Codes 80h, 81h and 82h preset a configuration-memory or user-memory address from the following data byte. A bare 84h arms a block read, which is signalled on the repeated start that follows. A bare 88h followed by a stop requests a reboot. Any other code is refused, and the rest of that transaction is ignored.

Top module: `smb_cmd_slave`

## Requirements
- R1: The address byte matches when bits 7..4 equal 1010b, bit 3 equals `a1_pin` and bit 2 equals `a0_pin`; bit 1 is ignored. A matching write address (bit 0 = 0) is ACKed. A non-matching address is NACKed, and every later byte up to the next start is NACKed with no output change.
- R2: A command byte in 00h..45h is ACKed and loads `reg_ptr` with that code. A stop directly after it leaves only that pointer change.
- R3: A command byte that is not in 00h..45h, 80h, 81h, 82h, 84h or 88h is NACKed, and later bytes of that transaction are NACKed with no output change.
- R4: A data byte after a command in 00h..45h is ACKed and produces exactly one cycle of `rb_we` with `rb_addr` equal to the command and `rb_wdata` equal to the data.
- R5: A second data byte is ACKed. After a register command below 45h it is written to command+1. After command 45h it is NACKed and not written. Any third data byte is NACKed.
- R6: A data byte after 80h loads `cfg_addr`. After 81h it loads `usr_addr` and clears `usr_page`; after 82h it loads `usr_addr` and sets `usr_page`. A second data byte after these codes is ACKed but changes none of them. A stop directly after 80h..82h leaves `reg_ptr`, `cfg_addr`, `usr_addr` and `usr_page` unchanged.
- R7: After an ACKed 84h with no data byte, a repeated start gives one cycle of `blk_rd_start`, while a stop gives none. A data byte after 84h or 88h is NACKed.
- R8: After an ACKed 88h with no data byte, a stop gives one cycle of `reboot`. A transaction that carries a data byte after 88h gives none.
- R9: After reset all outputs are 0. `sda_oe` is high only from the SCL fall that ends the eighth bit of an ACKed byte to the SCL fall that ends the ninth bit.
- R10: A matching read address (bit 0 = 1) is ACKed, and the block then NACKs and ignores everything until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| a1_pin | input | 1 | Upper address strap |
| a0_pin | input | 1 | Lower address strap |
| sda_oe | output | 1 | Pull SDA low when high (open drain) |
| rb_we | output | 1 | Register bank write strobe |
| rb_addr | output | 7 | Register bank write address |
| rb_wdata | output | 8 | Register bank write data |
| reg_ptr | output | 8 | Register pointer |
| cfg_addr | output | 8 | Configuration-memory address preset |
| usr_addr | output | 8 | User-memory address preset |
| usr_page | output | 1 | User-memory half chosen by 81h (0) or 82h (1) |
| blk_rd_start | output | 1 | One-cycle block read request |
| reboot | output | 1 | One-cycle reboot request |

## Verification
The bench builds the block with its default device type 1010b and a last register code of 45h. With these values both the top legal register code and the first refused code 46h can be reached, as can the word write that would run past the bank end. The strap inputs are changed partway through the run, so address matching is exercised against more than one strap value. SCL runs at six system clocks per half period, which leaves room for the three-cycle synchroniser lag before each acknowledge and each release.

// File: rtl/smb_cmd_slave.sv
module smb_cmd_slave #(
  parameter logic [3:0]  DEV_TYPE = 4'b1010,
  parameter int unsigned REG_LAST = 'h45,
  parameter int unsigned RA_W     = $clog2(REG_LAST + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  input  logic            a1_pin,
  input  logic            a0_pin,
  output logic            sda_oe,
  output logic            rb_we,
  output logic [RA_W-1:0] rb_addr,
  output logic [7:0]      rb_wdata,
  output logic [7:0]      reg_ptr,
  output logic [7:0]      cfg_addr,
  output logic [7:0]      usr_addr,
  output logic            usr_page,
  output logic            blk_rd_start,
  output logic            reboot
);
  localparam logic [7:0] LAST_B = 8'(REG_LAST);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_D1, S_D2, S_SKIP} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  st_t        st, nxt;
  logic [3:0] bitcnt;
  logic       in_ack, ack;
  logic [7:0] sh, cmd_q;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] cmd_nx = cmd_q + 8'd1;
  wire cmd_reg  = cmd_q <= LAST_B;
  wire cmd_mem  = cmd_q inside {8'h80, 8'h81, 8'h82};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in}; sda_sy <= {sda_sy[0], sda_in};
      scl_q  <= scl_s;                sda_q  <= sda_s;
    end

  always_comb begin
    ack = 1'b0;
    nxt = S_SKIP;
    case (st)
      S_ADDR: begin
        ack = sh[7:4] == DEV_TYPE && sh[3] == a1_pin && sh[2] == a0_pin;
        nxt = (ack && !sh[0]) ? S_CMD : S_SKIP;
      end
      S_CMD: begin
        ack = sh <= LAST_B || sh inside {8'h80, 8'h81, 8'h82, 8'h84, 8'h88};
        nxt = ack ? S_D1 : S_SKIP;
      end
      S_D1: begin
        ack = cmd_reg || cmd_mem;
        nxt = ack ? S_D2 : S_SKIP;
      end
      S_D2: ack = cmd_q < LAST_B || cmd_mem;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; in_ack <= 1'b0; sh <= '0; cmd_q <= '0;
      sda_oe <= 1'b0; rb_we <= 1'b0; rb_addr <= '0; rb_wdata <= '0;
      reg_ptr <= '0; cfg_addr <= '0; usr_addr <= '0; usr_page <= 1'b0;
      blk_rd_start <= 1'b0; reboot <= 1'b0;
    end else begin
      rb_we <= 1'b0; blk_rd_start <= 1'b0; reboot <= 1'b0;
      if (start_c) begin
        blk_rd_start <= st == S_D1 && cmd_q == 8'h84;
        st <= S_ADDR; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        reboot <= st == S_D1 && cmd_q == 8'h88;
        st <= S_IDLE; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise && bitcnt < 4'd8) begin
          sh <= {sh[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
        if (scl_fall && in_ack) begin
          in_ack <= 1'b0; sda_oe <= 1'b0; bitcnt <= '0;
        end else if (scl_fall && bitcnt == 4'd8) begin
          in_ack <= 1'b1; sda_oe <= ack; st <= nxt;
          if (ack)
            case (st)
              S_CMD: begin
                cmd_q <= sh;
                if (sh <= LAST_B) reg_ptr <= sh;
              end
              S_D1:
                if (cmd_reg) begin
                  rb_we <= 1'b1; rb_addr <= cmd_q[RA_W-1:0]; rb_wdata <= sh;
                end else if (cmd_q == 8'h80) cfg_addr <= sh;
                else begin
                  usr_addr <= sh; usr_page <= cmd_q[1];
                end
              S_D2:
                if (cmd_q < LAST_B) begin
                  rb_we <= 1'b1; rb_addr <= cmd_nx[RA_W-1:0]; rb_wdata <= sh;
                end
              default: ;
            endcase
        end
      end
    end
endmodule

// File: rtl/smb_cmd_slave_chk.sv
module smb_cmd_slave_chk #(
  parameter int unsigned REG_LAST = 'h45,
  parameter int unsigned RA_W     = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_in,
  input logic            sda_oe,
  input logic            rb_we,
  input logic [RA_W-1:0] rb_addr,
  input logic [7:0]      reg_ptr,
  input logic            blk_rd_start,
  input logic            reboot
);
  // R4
  bank_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_we |-> rb_addr <= RA_W'(REG_LAST));
  // R4
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_we |=> !rb_we);
  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_ptr) |-> reg_ptr <= 8'(REG_LAST));
  // R8
  reboot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot |=> !reboot);
  // R7
  blk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_rd_start |=> !blk_rd_start);
  // R7
  no_pulse_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_rd_start && reboot));
  // R9
  sda_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_in);
endmodule

bind smb_cmd_slave smb_cmd_slave_chk #(.REG_LAST(REG_LAST), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe), .rb_we(rb_we),
  .rb_addr(rb_addr), .reg_ptr(reg_ptr), .blk_rd_start(blk_rd_start), .reboot(reboot)
);

// File: tb/test_smb_cmd_slave.sv
`timescale 1ns/1ps
module test_smb_cmd_slave;
  localparam int H = 6;
  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, a1 = 1, a0 = 0;
  logic sda_oe, rb_we, usr_page, blk_rd_start, reboot;
  logic [6:0] rb_addr;
  logic [7:0] rb_wdata, reg_ptr, cfg_addr, usr_addr;
  wire sda_bus = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  smb_cmd_slave i_smb_cmd_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .a1_pin(a1), .a0_pin(a0), .sda_oe(sda_oe), .rb_we(rb_we),
    .rb_addr(rb_addr), .rb_wdata(rb_wdata), .reg_ptr(reg_ptr),
    .cfg_addr(cfg_addr), .usr_addr(usr_addr), .usr_page(usr_page),
    .blk_rd_start(blk_rd_start), .reboot(reboot));

  int vec = 0, mis = 0, cyc = 0;
  int act_rb = 0, act_blk = 0, exp_rb = 0, exp_blk = 0;
  bit settled = 0, ack_win = 0, done = 0;
  logic [7:0] m_ptr = 0, m_cfg = 0, m_usr = 0;
  logic m_page = 0;
  logic [7:0] qa[$], qd[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    vec++;
    if (act != exp) begin
      mis++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      if (blk_rd_start) act_blk++;
      if (reboot) act_rb++;
      if (sda_oe && !ack_win) chk("R9", "sda_oe outside ack window", 1, 0);
      if (rb_we) begin
        if (qa.size() == 0) chk("R4", "unexpected bank write", 1, 0);
        else begin
          chk("R4", "write addr", rb_addr, qa.pop_front());
          chk("R4", "write data", rb_wdata, qd.pop_front());
        end
      end
      if (settled) begin
        chk("R2", "reg_ptr", reg_ptr, m_ptr);
        chk("R6", "cfg_addr", cfg_addr, m_cfg);
        chk("R6", "usr_addr", usr_addr, m_usr);
        chk("R6", "usr_page", usr_page, m_page);
      end
    end
    if (cyc > 150000 && !done) begin
      mis++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  end

  task automatic do_start();
    sda_m = 1; scl_m = 1; tick(H);
    sda_m = 0; tick(H);
    scl_m = 0; tick(H);
  endtask

  task automatic do_rstart();
    sda_m = 1; tick(H);
    scl_m = 1; tick(H);
    sda_m = 0; tick(H);
    scl_m = 0; tick(H);
  endtask

  task automatic do_stop();
    sda_m = 0; tick(H);
    scl_m = 1; tick(H);
    sda_m = 1; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(H);
      scl_m = 1; tick(H);
      scl_m = 0;
    end
    ack_win = 1;
    sda_m = 1; tick(H);
    scl_m = 1; tick(H / 2);
    ack = !sda_bus;
    tick(H - H / 2);
    scl_m = 0; tick(4);
    ack_win = 0;
  endtask

  task automatic xfer(input bit fresh, input logic [7:0] ab, input int n,
                      input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3,
                      input bit rep, input string req);
    logic [7:0] bs[4];
    int ph;
    logic [7:0] c;
    bit ea, got;
    bs = '{ab, b1, b2, b3};
    ph = 0; c = 0;
    settled = 0;
    if (fresh) do_start();
    for (int k = 0; k <= n; k++) begin
      ea = 0;
      case (ph)
        0: begin
          ea = bs[0][7:4] == 4'hA && bs[0][3] == a1 && bs[0][2] == a0;
          ph = (ea && !bs[0][0]) ? 1 : 4;
        end
        1: begin
          c = bs[k];
          ea = c <= 8'h45 || c == 8'h80 || c == 8'h81 || c == 8'h82 || c == 8'h84 || c == 8'h88;
          if (ea && c <= 8'h45) m_ptr = c;
          ph = ea ? 2 : 4;
        end
        2: begin
          if (c <= 8'h45) begin ea = 1; qa.push_back(c); qd.push_back(bs[k]); end
          else if (c == 8'h80) begin ea = 1; m_cfg = bs[k]; end
          else if (c == 8'h81) begin ea = 1; m_usr = bs[k]; m_page = 0; end
          else if (c == 8'h82) begin ea = 1; m_usr = bs[k]; m_page = 1; end
          ph = ea ? 3 : 4;
        end
        3: begin
          if (c < 8'h45) begin ea = 1; qa.push_back(c + 8'd1); qd.push_back(bs[k]); end
          else if (c >= 8'h80 && c <= 8'h82) ea = 1;
          ph = 4;
        end
        default: ea = 0;
      endcase
      send_byte(bs[k], got);
      chk(req, $sformatf("ack of byte %0d (%0h)", k, bs[k]), got, ea);
    end
    if (rep) begin
      if (ph == 2 && c == 8'h84) exp_blk++;
      do_rstart();
    end else begin
      if (ph == 2 && c == 8'h88) exp_rb++;
      do_stop();
    end
    tick(6);
    chk(req, "pending writes", qa.size(), 0);
    chk(req, "reboot pulses", act_rb, exp_rb);
    chk(req, "block read pulses", act_blk, exp_blk);
    if (!rep) settled = 1;
    tick(4);
  endtask

  initial begin
    tick(3);
    chk("R9", "reset sda_oe", sda_oe, 0);
    chk("R9", "reset reg_ptr", reg_ptr, 0);
    chk("R9", "reset rb_we", rb_we, 0);
    chk("R9", "reset reboot", reboot, 0);
    rst_n = 1;
    tick(4);
    settled = 1;
    chk("R9", "idle cfg_addr", cfg_addr, 0);
    // R2 send byte presets pointer
    xfer(1, 8'hA8, 1, 8'h12, 0, 0, 0, "R2");
    // R2 bit 1 of address is ignored
    xfer(1, 8'hAA, 1, 8'h45, 0, 0, 0, "R2");
    // R4 single register write
    xfer(1, 8'hA8, 2, 8'h05, 8'hA5, 0, 0, "R4");
    // R5 word write and refused third byte
    xfer(1, 8'hA8, 4, 8'h10, 8'h11, 8'h22, 8'h33, "R5");
    // R5 word at last register: second byte refused
    xfer(1, 8'hA8, 3, 8'h45, 8'h5A, 8'h6B, 0, "R5");
    // R3 first refused code and an odd one
    xfer(1, 8'hA8, 2, 8'h46, 8'h77, 0, 0, "R3");
    xfer(1, 8'hA8, 2, 8'h83, 8'h78, 0, 0, "R3");
    // R6 memory address presets
    xfer(1, 8'hA8, 2, 8'h80, 8'h3C, 0, 0, "R6");
    xfer(1, 8'hA8, 2, 8'h82, 8'h09, 0, 0, "R6");
    xfer(1, 8'hA8, 3, 8'h81, 8'h07, 8'hEE, 0, "R6");
    xfer(1, 8'hA8, 1, 8'h80, 0, 0, 0, "R6");
    xfer(1, 8'hA8, 1, 8'h82, 0, 0, 0, "R6");
    // R7 block read armed, then repeated start with read address
    xfer(1, 8'hA8, 1, 8'h84, 0, 0, 1, "R7");
    xfer(0, 8'hA9, 0, 0, 0, 0, 0, "R10");
    xfer(1, 8'hA8, 1, 8'h84, 0, 0, 0, "R7");
    xfer(1, 8'hA8, 2, 8'h84, 8'h01, 0, 0, "R7");
    // R8 reboot, and its refused data form
    xfer(1, 8'hA8, 1, 8'h88, 0, 0, 0, "R8");
    xfer(1, 8'hA8, 2, 8'h88, 8'h02, 0, 0, "R8");
    // R1 mismatching addresses ignore everything after
    xfer(1, 8'hA0, 2, 8'h07, 8'h99, 0, 0, "R1");
    xfer(1, 8'hB8, 2, 8'h07, 8'h98, 0, 0, "R1");
    // R10 read address then ignored bytes
    xfer(1, 8'hA9, 2, 8'h07, 8'h97, 0, 0, "R10");
    // R1 strap change
    a1 = 0; a0 = 1; tick(4);
    xfer(1, 8'hA8, 2, 8'h07, 8'h96, 0, 0, "R1");
    xfer(1, 8'hA4, 2, 8'h08, 8'h95, 0, 0, "R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule